// File: doc/BRIEF.md
# Dual-Path Deskew and Hitless Channel Selector

This block takes two byte streams that run at the same rate and carry the same framed payload over two redundant paths. Each stream has a frame-start marker that is already found upstream. The block writes each stream into its own small FIFO. It starts both FIFOs at the frame-start byte of their own stream, and it reads both together once the later stream has shown its marker. The byte at the head of one FIFO is then always the same frame position as the byte at the head of the other FIFO. The block forwards one of these two aligned streams.

The path is chosen in one of two ways. In manual mode a select input picks the path. In automatic mode the block moves away from the current path when that path has a frame-error or error-rate alarm and the other path has neither. Both paths are aligned, so a change of path causes no slip: no byte is lost and no byte is repeated. A lock-loss alarm on either path is registered and reported, and it never changes the selection. A loss-of-alignment output is high while the two paths cannot be lined up. The selection is frozen while this output is high.

Top module: `hitless_sel`

## Requirements
- R1: While reset is low, `out_valid` is 0, `loa` is 1, `cur_ch` is 0 and `switch_pulse` is 0.
- R2: When the frame-start markers of the two inputs arrive within `MAX_SKEW` byte slots of each other, in either order, `loa` falls. From then on, `out_valid` is high on every cycle, and the first valid output byte is a frame-start byte.
- R3: While aligned, the output carries the input stream byte for byte, with no gap and no repeat. `out_sof` marks exactly the frame-start bytes.
- R4: When the markers are more than `MAX_SKEW` slots apart, `loa` stays 1 and `out_valid` stays 0.
- R5: When the frame-start flags at the two FIFO heads disagree after alignment, `loa` rises and `out_valid` is 0 in the next cycle. The block then hunts again, and it realigns when the skew is back in range.
- R6: With `auto_en`=0 and `loa`=0, `cur_ch` takes the value of `man_sel` at the next clock edge. Output bytes then come from that channel: channel 0 when `cur_ch`=0, channel 1 when `cur_ch`=1.
- R7: While `loa` is 1, `cur_ch` does not change, whatever `man_sel`, `auto_en` or the alarms do.
- R8: With `auto_en`=1 and `loa`=0, the block switches to the other channel when the current channel has `sef` or `ber` set and the other channel has neither. When both channels or neither channel are alarmed, it stays on the current channel. In this mode `man_sel` is not used.
- R9: `lol` never changes `cur_ch`. `lol_flag` shows the `lol` value of the previous cycle. Bit k of `lol`, `sef` and `ber` belongs to channel k.
- R10: `switch_pulse` is high for exactly the one cycle after each change of `cur_ch`, and it is low at all other times.
- R11: A change of channel while aligned keeps the output sequence contiguous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock shared by both paths |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | 1 = alarms drive the selection, 0 = `man_sel` drives it |
| man_sel | input | 1 | Manual channel choice |
| ch0_data | input | DATA_W | Byte stream of path 0 |
| ch0_sof | input | 1 | Frame-start marker of path 0 |
| ch1_data | input | DATA_W | Byte stream of path 1 |
| ch1_sof | input | 1 | Frame-start marker of path 1 |
| sef | input | 2 | Severely-errored-frame alarm per channel |
| ber | input | 2 | Error-rate alarm per channel |
| lol | input | 2 | Lock-loss alarm per channel (reported only) |
| out_data | output | DATA_W | Selected aligned byte |
| out_sof | output | 1 | Frame-start marker of `out_data` |
| out_valid | output | 1 | `out_data` holds a byte |
| cur_ch | output | 1 | Channel currently selected |
| switch_pulse | output | 1 | One-cycle pulse after each channel change |
| loa | output | 1 | Loss of alignment |
| lol_flag | output | 2 | Registered lock-loss alarms |

## Verification
The hardest states to reach from the ports are a skew change in the middle of a run and a skew just outside the window. Only these two states make the FIFO heads disagree, or make the hunt time out again and again. The bench delays each path by its own number of byte slots. It moves the delay of path 1 while the block is locked, through +20, -24 and +24 slots and then to +30 slots. During the out-of-range phase it requests a new channel, to show that the selection stays frozen. A scoreboard follows path 0 and requires an unbroken sequence through every relock and every change of channel.

// File: rtl/hsel_pkg.sv
`timescale 1ns/1ps
package hsel_pkg;

  typedef enum logic {
    AL_HUNT = 1'b0,
    AL_LOCK = 1'b1
  } align_st_e;

  function automatic int abs_gap(input int a, input int b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/hsel_fifo.sv
`timescale 1ns/1ps
module hsel_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [LW-1:0]    level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_n;
  logic [AW-1:0]    rptr_q, rptr_n;
  logic [LW-1:0]    lvl_q, lvl_n;
  logic             full;

  always_comb begin
    full   = (lvl_q == LW'(DEPTH));
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    lvl_n  = lvl_q;
    if (clr) begin
      wptr_n = '0;
      rptr_n = '0;
      lvl_n  = '0;
    end else begin
      if (wr_en) wptr_n = wptr_q + 1'b1;
      if (rd_en) rptr_n = rptr_q + 1'b1;
      if (wr_en && !rd_en) lvl_n = lvl_q + 1'b1;
      else if (!wr_en && rd_en) lvl_n = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      lvl_q  <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wptr_q] <= wr_data;
  end

  assign rd_data = mem[rptr_q];
  assign level   = lvl_q;

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !clr) |-> !full);
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !clr) |-> (lvl_q != '0));

endmodule

// File: rtl/hsel_align.sv
`timescale 1ns/1ps
module hsel_align
  import hsel_pkg::*;
#(
  parameter int MAX_SKEW = 24,
  parameter int LW = 6,
  localparam int CW = $clog2(MAX_SKEW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sof_in,
  input  logic [1:0]    head_sof,
  input  logic [LW-1:0] lvl0,
  input  logic [LW-1:0] lvl1,
  output logic [1:0]    wr_en,
  output logic          rd_en,
  output logic          clr,
  output logic          loa
);

  align_st_e   st_q, st_n;
  logic [1:0]  seen_q, seen_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic        mismatch;

  always_comb begin
    st_n     = st_q;
    seen_n   = seen_q;
    cnt_n    = cnt_q;
    wr_en    = 2'b00;
    rd_en    = 1'b0;
    clr      = 1'b0;
    mismatch = (st_q == AL_LOCK) && (head_sof[0] != head_sof[1]);
    case (st_q)
      AL_HUNT: begin
        seen_n = seen_q | sof_in;
        wr_en  = seen_n;
        if (seen_n == 2'b11) begin
          st_n  = AL_LOCK;
          cnt_n = '0;
        end else if (seen_n != 2'b00) begin
          if (seen_q == 2'b00) begin
            cnt_n = '0;
          end else if (cnt_q == CW'(MAX_SKEW - 1)) begin
            clr    = 1'b1;
            wr_en  = 2'b00;
            seen_n = 2'b00;
            cnt_n  = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        wr_en = 2'b11;
        if (mismatch) begin
          st_n   = AL_HUNT;
          clr    = 1'b1;
          wr_en  = 2'b00;
          seen_n = 2'b00;
        end else begin
          rd_en = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= AL_HUNT;
      seen_q <= 2'b00;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_n;
      seen_q <= seen_n;
      cnt_q  <= cnt_n;
    end
  end

  assign loa = (st_q != AL_LOCK);

  // R2: while locked, the two FIFO fills differ by the skew, which is within range
  a_r2_skew_span: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == AL_LOCK) |-> (abs_gap(int'(lvl0), int'(lvl1)) <= MAX_SKEW));

endmodule

// File: rtl/hsel_choose.sv
`timescale 1ns/1ps
module hsel_choose (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_en,
  input  logic       man_sel,
  input  logic       hold,
  input  logic [1:0] bad,
  output logic       sel_nxt,
  output logic       sel_q,
  output logic       pulse_q
);

  logic sel_r;
  logic pulse_r;

  always_comb begin
    sel_nxt = sel_r;
    if (!hold) begin
      if (auto_en) begin
        if (bad[sel_r] && !bad[!sel_r]) sel_nxt = !sel_r;
      end else begin
        sel_nxt = man_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_r   <= 1'b0;
      pulse_r <= 1'b0;
    end else begin
      sel_r   <= sel_nxt;
      pulse_r <= (sel_nxt != sel_r);
    end
  end

  assign sel_q   = sel_r;
  assign pulse_q = pulse_r;

  a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(sel_r));
  a_r6_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && !hold) |=> (sel_r == $past(man_sel)));
  a_r8_failover: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !hold && bad[sel_r] && !bad[!sel_r]) |=> (sel_r != $past(sel_r)));
  a_r8_both_bad_stay: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !hold && (bad == 2'b11)) |=> $stable(sel_r));
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_r == (sel_r != $past(sel_r)));

endmodule

// File: rtl/hitless_sel.sv
`timescale 1ns/1ps
module hitless_sel #(
  parameter int DATA_W   = 8,
  parameter int MAX_SKEW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              man_sel,
  input  logic [DATA_W-1:0] ch0_data,
  input  logic              ch0_sof,
  input  logic [DATA_W-1:0] ch1_data,
  input  logic              ch1_sof,
  input  logic [1:0]        sef,
  input  logic [1:0]        ber,
  input  logic [1:0]        lol,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_valid,
  output logic              cur_ch,
  output logic              switch_pulse,
  output logic              loa,
  output logic [1:0]        lol_flag
);

  localparam int FIFO_DEPTH = 2 ** $clog2(MAX_SKEW + 2);
  localparam int WORD_W     = DATA_W + 1;
  localparam int LVL_W      = $clog2(FIFO_DEPTH) + 1;

  logic [WORD_W-1:0] wr_word [2];
  logic [WORD_W-1:0] head    [2];
  logic [LVL_W-1:0]  lvl     [2];
  logic [1:0]        wr_en;
  logic [1:0]        head_sof;
  logic              rd_en;
  logic              clr;
  logic              sel_nxt;

  assign wr_word[0] = {ch0_sof, ch0_data};
  assign wr_word[1] = {ch1_sof, ch1_data};

  for (genvar g = 0; g < 2; g++) begin : g_path
    hsel_fifo #(
      .WIDTH (WORD_W),
      .DEPTH (FIFO_DEPTH)
    ) i_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .wr_en   (wr_en[g]),
      .wr_data (wr_word[g]),
      .rd_en   (rd_en),
      .rd_data (head[g]),
      .level   (lvl[g])
    );
    assign head_sof[g] = head[g][WORD_W-1];
  end

  hsel_align #(
    .MAX_SKEW (MAX_SKEW),
    .LW       (LVL_W)
  ) i_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .sof_in   ({ch1_sof, ch0_sof}),
    .head_sof (head_sof),
    .lvl0     (lvl[0]),
    .lvl1     (lvl[1]),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .clr      (clr),
    .loa      (loa)
  );

  hsel_choose i_choose (
    .clk     (clk),
    .rst_n   (rst_n),
    .auto_en (auto_en),
    .man_sel (man_sel),
    .hold    (loa),
    .bad     (sef | ber),
    .sel_nxt (sel_nxt),
    .sel_q   (cur_ch),
    .pulse_q (switch_pulse)
  );

  // output stage: mux with the same next selection that updates cur_ch
  logic [DATA_W-1:0] od_q, od_n;
  logic              os_q, os_n;
  logic              ov_q;
  logic [1:0]        lf_q;

  always_comb begin
    od_n = sel_nxt ? head[1][DATA_W-1:0] : head[0][DATA_W-1:0];
    os_n = sel_nxt ? head_sof[1] : head_sof[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q <= '0;
      os_q <= 1'b0;
      ov_q <= 1'b0;
      lf_q <= 2'b00;
    end else begin
      ov_q <= rd_en;
      lf_q <= lol;
      if (rd_en) begin
        od_q <= od_n;
        os_q <= os_n;
      end else begin
        os_q <= 1'b0;
      end
    end
  end

  assign out_data  = od_q;
  assign out_sof   = os_q;
  assign out_valid = ov_q;
  assign lol_flag  = lf_q;

  a_r5_no_output_unaligned: assert property (@(posedge clk) disable iff (!rst_n)
    loa |=> !out_valid);
  a_r2_first_is_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loa) |=> (out_valid && out_sof));
  a_r9_lol_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !loa && ((sef | ber) == 2'b00)) |=> $stable(cur_ch));
  a_r9_lol_report: assert property (@(posedge clk) disable iff (!rst_n)
    lol_flag == $past(lol));

endmodule

// File: tb/test_hitless_sel.sv
`timescale 1ns/1ps
module test_hitless_sel;

  localparam int FRAME = 64;
  localparam int D0    = 24;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       auto_en, man_sel;
  logic [7:0] ch0_data, ch1_data;
  logic       ch0_sof, ch1_sof;
  logic [1:0] sef, ber, lol;
  logic [7:0] out_data;
  logic       out_sof, out_valid, cur_ch, switch_pulse, loa;
  logic [1:0] lol_flag;

  always #2 clk = ~clk;

  hitless_sel #(.DATA_W(8), .MAX_SKEW(24)) i_hitless_sel (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .man_sel(man_sel),
    .ch0_data(ch0_data), .ch0_sof(ch0_sof), .ch1_data(ch1_data), .ch1_sof(ch1_sof),
    .sef(sef), .ber(ber), .lol(lol),
    .out_data(out_data), .out_sof(out_sof), .out_valid(out_valid),
    .cur_ch(cur_ch), .switch_pulse(switch_pulse), .loa(loa), .lol_flag(lol_flag)
  );

  int total = 0;
  int bad   = 0;
  int n     = 0;
  int d1    = D0;
  int pulse_cnt = 0;
  int cyc   = 0;
  bit need_sync = 1'b1;
  bit prev_cur  = 1'b0;
  logic [6:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // driver: path 0 delayed by D0 slots, path 1 by d1 slots; bit 7 tags the path
  task automatic drive_byte();
    int v0, v1;
    v0 = n - D0;
    v1 = n - d1;
    ch0_data = (v0 >= 0) ? {1'b0, 7'(v0)} : 8'h00;
    ch0_sof  = (v0 >= 0) && (v0 % FRAME == 0);
    ch1_data = (v1 >= 0) ? {1'b1, 7'(v1)} : 8'h80;
    ch1_sof  = (v1 >= 0) && (v1 % FRAME == 0);
    if (v0 >= 0) exp_q.push_back(7'(v0));
    n++;
  endtask

  // monitor then driver, in one process at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!out_valid) begin
        need_sync = 1'b1;
        while (exp_q.size() > 40) void'(exp_q.pop_front());
      end else begin
        logic [6:0] got;
        got = out_data[6:0];
        if (need_sync) begin
          chk(out_sof == 1'b1, "R2 first byte after lock is frame start", out_sof, 1);
          while (exp_q.size() > 0 && exp_q[0] != got) void'(exp_q.pop_front());
          chk(exp_q.size() > 0, "R3 first byte found in stream", got, -1);
          if (exp_q.size() > 0) void'(exp_q.pop_front());
          need_sync = 1'b0;
        end else begin
          logic [6:0] e;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 7'h7f;
          chk(got == e, "R3 R11 contiguous byte", got, e);
        end
        chk(out_sof == (got[5:0] == 6'd0), "R3 frame marker position", out_sof, got[5:0] == 6'd0);
        chk(out_data[7] == cur_ch, "R6 byte from selected path", out_data[7], cur_ch);
      end
      chk(switch_pulse == (cur_ch != prev_cur), "R10 pulse after change", switch_pulse, cur_ch != prev_cur);
      if (switch_pulse) pulse_cnt++;
      prev_cur = cur_ch;
    end
    drive_byte();
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
    end
  end

  task automatic wait_loa(input bit val, input int max, input string tag);
    bit hit;
    hit = 1'b0;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (loa == val) begin
        hit = 1'b1;
        break;
      end
    end
    chk(hit, tag, loa, val);
  endtask

  initial begin
    int p0, errs;
    rst_n = 1'b0; auto_en = 1'b0; man_sel = 1'b0;
    sef = 2'b00; ber = 2'b00; lol = 2'b00;
    ch0_data = '0; ch1_data = '0; ch0_sof = 1'b0; ch1_sof = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    chk(loa == 1'b1, "R1 reset loa", loa, 1);
    chk(cur_ch == 1'b0, "R1 reset cur_ch", cur_ch, 0);
    chk(switch_pulse == 1'b0, "R1 reset pulse", switch_pulse, 0);
    rst_n = 1'b1;

    wait_loa(1'b0, 300, "R2 lock at zero skew");
    repeat (150) @(negedge clk);

    p0 = pulse_cnt;
    man_sel = 1'b1;
    repeat (2) @(negedge clk);
    chk(cur_ch == 1'b1, "R6 manual select path 1", cur_ch, 1);
    chk(pulse_cnt == p0 + 1, "R10 one pulse per change", pulse_cnt, p0 + 1);
    repeat (100) @(negedge clk);
    man_sel = 1'b0;
    repeat (2) @(negedge clk);
    chk(cur_ch == 1'b0, "R6 manual select path 0", cur_ch, 0);
    repeat (20) @(negedge clk);

    // path 1 later by 20
    d1 = D0 + 20;
    wait_loa(1'b1, 150, "R5 realign after skew shift");
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 output stops", out_valid, 0);
    wait_loa(1'b0, 300, "R2 lock with skew +20");
    repeat (150) @(negedge clk);

    // path 1 earlier by the full window
    d1 = 0;
    wait_loa(1'b1, 150, "R5 realign after skew shift to -24");
    wait_loa(1'b0, 300, "R2 lock with skew -24");
    repeat (150) @(negedge clk);

    // path 1 later by the full window
    d1 = D0 + 24;
    wait_loa(1'b1, 150, "R5 realign after skew shift to +24");
    wait_loa(1'b0, 300, "R2 lock with skew +24");
    repeat (150) @(negedge clk);

    // out of range
    d1 = D0 + 30;
    wait_loa(1'b1, 150, "R5 alarm on skew +30");
    man_sel = 1'b1;
    errs = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!loa || out_valid) errs++;
    end
    chk(errs == 0, "R4 no lock beyond window", errs, 0);
    chk(cur_ch == 1'b0, "R7 selection frozen during loa", cur_ch, 0);

    d1 = D0;
    wait_loa(1'b0, 300, "R2 relock at zero skew");
    repeat (3) @(negedge clk);
    chk(cur_ch == 1'b1, "R6 pending choice applied after relock", cur_ch, 1);
    repeat (50) @(negedge clk);

    // automatic mode
    auto_en = 1'b1;
    man_sel = 1'b0;
    repeat (5) @(negedge clk);
    chk(cur_ch == 1'b1, "R8 no alarm keeps path", cur_ch, 1);
    sef = 2'b10;
    repeat (2) @(negedge clk);
    chk(cur_ch == 1'b0, "R8 frame alarm moves to path 0", cur_ch, 0);
    sef = 2'b00;
    ber = 2'b01;
    repeat (2) @(negedge clk);
    chk(cur_ch == 1'b1, "R8 rate alarm moves to path 1", cur_ch, 1);
    sef = 2'b10;
    repeat (20) @(negedge clk);
    chk(cur_ch == 1'b1, "R8 both alarmed stays", cur_ch, 1);
    sef = 2'b00;
    ber = 2'b00;
    repeat (5) @(negedge clk);

    lol = 2'b10;
    @(negedge clk);
    chk(lol_flag == 2'b10, "R9 lock loss reported", lol_flag, 2);
    repeat (20) @(negedge clk);
    chk(cur_ch == 1'b1, "R9 lock loss does not switch", cur_ch, 1);
    lol = 2'b00;
    repeat (50) @(negedge clk);

    summary();
  end

endmodule